// File: doc/BRIEF.md
# Host Command/Data Port Controller

This block is the controller side of a two-port byte interface used by a host to talk to an embedded controller. The host writes command bytes to a command port and parameter bytes to a data port. A read of the command port returns a status byte, and a read of the data port returns the byte the controller has placed for the host. The status byte carries the handshake flags that the host polls between steps of a transaction.

The controller carries out three transactions against a small internal byte space: a read (command, address, then a result byte), a write (command, address, value) and an event query that pulls the next pending event number from an external event unit. The internal space holds a version byte, a self-test pair whose second byte is always the complement of the first, and a backlight level limited to 0..100. Bus cycle decoding and interrupt routing live outside this block. The block sees port selects and read/write strobes, plus two pending-event inputs that it only reflects in the status byte.

Top module: `hcp_ctrl`

## Requirements
- R1: After a synchronous active-low reset with both pending inputs low, the status byte reads 0x00, the data register reads 0x00 and the backlight byte (address 3) reads 100.
- R2: A host write to either port sets status bit 1 (input full) on the next clock. The controller consumes the byte one clock later, which clears bit 1. Status bit 3 is 1 when the latest host write went to the command port and 0 when it went to the data port.
- R3: A command-port read returns the status byte with no side effect. A data-port read returns the data register and clears status bit 0 (output full) on that clock edge.
- R4: Status bits 4 and 7 always read 0. Bit 5 follows the SCI-pending input and bit 6 follows the SMI-pending input.
- R5: Status bit 2 (processing) is set from the consumption of command 0x80 or 0x81 until the final data byte of that transaction is consumed. While it is set, the host sees busy, which is bit 1 OR bit 2.
- R6: Read: command 0x80, then an address byte on the data port. When the address is consumed, the byte at that address is loaded into the data register and status bit 0 is set.
- R7: Write: command 0x81, then an address byte, then a value byte, both on the data port. The value is stored when it is consumed, and no data byte is returned.
- R8: Query command 0x84 loads the pending event code into the data register, sets bit 0 and pulses the event acknowledge for one cycle. With no event pending it loads 0x00 and gives no acknowledge.
- R9: Any other command byte is consumed and ignored. It leaves bit 2 and bit 0 clear and changes no stored byte.
- R10: Address 0 reads 0x01 and ignores writes.
- R11: A write to address 1 stores the value there and stores 0xFF minus the value at address 2. Writes to address 2 are ignored.
- R12: Address 3 holds the backlight level. A written value above 100 is stored as 100. Unmapped addresses read 0x00 and ignore writes.
- R13: A command byte that arrives in the middle of a transaction abandons that transaction. A data byte that arrives with no transaction open is consumed and ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hst_sel_cmd | input | 1 | Host access targets the command/status port |
| hst_sel_data | input | 1 | Host access targets the data port |
| hst_wr | input | 1 | Host write strobe, one cycle per byte |
| hst_rd | input | 1 | Host read strobe, one cycle per byte |
| hst_wdata | input | 8 | Byte written by the host |
| hst_rdata | output | 8 | Status byte when the command port is selected, otherwise the data register |
| sci_pend | input | 1 | SCI event pending, reflected in status bit 5 |
| smi_pend | input | 1 | SMI event pending, reflected in status bit 6 |
| evt_valid | input | 1 | External event unit has an event waiting |
| evt_code | input | 8 | Number of the waiting event |
| evt_ack | output | 1 | One-cycle pulse when a query takes the waiting event |

## Verification
The bench follows the status byte through every step of a transaction. This catches a design that sets processing for a query or an ignored command, that leaves bit 1 set after consumption, or that keeps bit 0 set after the host has read the data. The self-test pair is written and read back, and address 2 is then written directly: a design that let that write through would break the complement. Backlight writes at 100 and above 100 expose a missing clamp. An abandoned write followed by a read shows whether a stale address or value was still committed, and a query with no event pending shows whether a stale code is returned or a spurious acknowledge is given.

// File: rtl/hcp_pkg.sv
// Shared constants and types for the host command/data port controller.
// Assumes byte-wide ports throughout.
package hcp_pkg;
    localparam int BYTE_W = 8;

    // status byte bit positions (the host decodes these)
    localparam int ST_OBF  = 0;
    localparam int ST_IBF  = 1;
    localparam int ST_PROC = 2;
    localparam int ST_CMD  = 3;
    localparam int ST_SCI  = 5;
    localparam int ST_SMI  = 6;

    // command codes
    localparam logic [BYTE_W-1:0] OP_READ  = 8'h80;
    localparam logic [BYTE_W-1:0] OP_WRITE = 8'h81;
    localparam logic [BYTE_W-1:0] OP_QUERY = 8'h84;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_RADDR,
        SQ_WADDR,
        SQ_WVAL
    } seq_state_t;
endpackage

// File: rtl/hcp_flags.sv
// Input and output byte registers plus the status byte.
// Assumes a host write and a consume in the same cycle keep the new byte.
module hcp_flags
    import hcp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_wr_cmd,
    input  logic [BYTE_W-1:0] host_wdata,
    input  logic              host_rd_data,
    input  logic              consume,
    input  logic              load_out,
    input  logic [BYTE_W-1:0] load_val,
    input  logic              proc,
    input  logic              sci,
    input  logic              smi,
    output logic              ibf,
    output logic              obf,
    output logic              in_is_cmd,
    output logic [BYTE_W-1:0] in_byte,
    output logic [BYTE_W-1:0] out_byte,
    output logic [BYTE_W-1:0] status
);
    // input-side register: latch host byte, drop full flag on consume
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ibf       <= 1'b0;
            in_is_cmd <= 1'b0;
            in_byte   <= '0;
        end else if (host_wr) begin
            ibf       <= 1'b1;
            in_is_cmd <= host_wr_cmd;
            in_byte   <= host_wdata;
        end else if (consume) begin
            ibf <= 1'b0;
        end
    end

    // output-side register: load from controller, drop full flag on host read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            obf      <= 1'b0;
            out_byte <= '0;
        end else if (load_out) begin
            obf      <= 1'b1;
            out_byte <= load_val;
        end else if (host_rd_data) begin
            obf <= 1'b0;
        end
    end

    // assemble the status byte; burst and reserved bits stay zero
    always_comb begin
        status          = '0;
        status[ST_OBF]  = obf;
        status[ST_IBF]  = ibf;
        status[ST_PROC] = proc;
        status[ST_CMD]  = in_is_cmd;
        status[ST_SCI]  = sci;
        status[ST_SMI]  = smi;
    end

    assert_rd_clears_obf_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_data && !load_out) |=> !obf);
endmodule

// File: rtl/hcp_space.sv
// Small byte-addressed space: version, self-test pair, backlight level.
// Assumes a combinational read and a single-cycle write strobe.
module hcp_space
    import hcp_pkg::*;
#(
    parameter logic [BYTE_W-1:0] VERSION  = 8'd1,
    parameter logic [BYTE_W-1:0] BKL_MAX  = 8'd100,
    parameter logic [BYTE_W-1:0] BKL_INIT = 8'd100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] addr,
    input  logic              we,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata
);
    localparam logic [BYTE_W-1:0] A_VER  = 8'd0;
    localparam logic [BYTE_W-1:0] A_TEST = 8'd1;
    localparam logic [BYTE_W-1:0] A_INV  = 8'd2;
    localparam logic [BYTE_W-1:0] A_BKL  = 8'd3;

    logic [BYTE_W-1:0] test_q, inv_q, bkl_q;

    // writable bytes; the complement byte only follows the test byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            test_q <= '0;
            inv_q  <= '1;
            bkl_q  <= BKL_INIT;
        end else if (we) begin
            if (addr == A_TEST) begin
                test_q <= wdata;
                inv_q  <= 8'hFF - wdata;
            end
            if (addr == A_BKL)
                bkl_q <= (wdata > BKL_MAX) ? BKL_MAX : wdata;
        end
    end

    // read mux, unmapped addresses read zero
    always_comb begin
        case (addr)
            A_VER:   rdata = VERSION;
            A_TEST:  rdata = test_q;
            A_INV:   rdata = inv_q;
            A_BKL:   rdata = bkl_q;
            default: rdata = '0;
        endcase
    end

    assert_pair_complement_R11: assert property (@(posedge clk) disable iff (!rst_n)
        inv_q == 8'hFF - test_q);
    assert_bkl_limit_R12: assert property (@(posedge clk) disable iff (!rst_n)
        bkl_q <= BKL_MAX);
endmodule

// File: rtl/hcp_seq.sv
// Transaction sequencer: consumes each host byte one cycle after it lands
// and steps the read, write and query transactions.
// Assumes the space read is combinational.
module hcp_seq
    import hcp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ibf,
    input  logic              in_is_cmd,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              evt_valid,
    input  logic [BYTE_W-1:0] evt_code,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              consume,
    output logic [BYTE_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              load_out,
    output logic [BYTE_W-1:0] load_val,
    output logic              proc,
    output logic              evt_ack
);
    seq_state_t        state_q, state_d;
    logic [BYTE_W-1:0] addr_q, addr_d;

    // decode the pending byte against the current step
    always_comb begin
        consume   = ibf;
        state_d   = state_q;
        addr_d    = addr_q;
        mem_addr  = addr_q;
        mem_we    = 1'b0;
        mem_wdata = in_byte;
        load_out  = 1'b0;
        load_val  = '0;
        evt_ack   = 1'b0;
        if (ibf) begin
            if (in_is_cmd) begin
                case (in_byte)
                    OP_READ:  state_d = SQ_RADDR;
                    OP_WRITE: state_d = SQ_WADDR;
                    OP_QUERY: begin
                        state_d  = SQ_IDLE;
                        load_out = 1'b1;
                        load_val = evt_valid ? evt_code : '0;
                        evt_ack  = evt_valid;
                    end
                    default:  state_d = SQ_IDLE;
                endcase
            end else begin
                case (state_q)
                    SQ_RADDR: begin
                        mem_addr = in_byte;
                        load_out = 1'b1;
                        load_val = mem_rdata;
                        state_d  = SQ_IDLE;
                    end
                    SQ_WADDR: begin
                        addr_d  = in_byte;
                        state_d = SQ_WVAL;
                    end
                    SQ_WVAL: begin
                        mem_we  = 1'b1;
                        state_d = SQ_IDLE;
                    end
                    default: state_d = SQ_IDLE;
                endcase
            end
        end
    end

    // step register and captured write address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
        end
    end

    assign proc = (state_q != SQ_IDLE);

    assert_write_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_WVAL && ibf && !in_is_cmd) |=> !proc);
endmodule

// File: rtl/hcp_ctrl.sv
// Top of the host command/data port controller: port decode, flag
// registers, transaction sequencer and internal byte space.
// Assumes one-cycle host strobes; the command port wins if both selects are high.
module hcp_ctrl
    import hcp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hst_sel_cmd,
    input  logic        hst_sel_data,
    input  logic        hst_wr,
    input  logic        hst_rd,
    input  logic [7:0]  hst_wdata,
    output logic [7:0]  hst_rdata,
    input  logic        sci_pend,
    input  logic        smi_pend,
    input  logic        evt_valid,
    input  logic [7:0]  evt_code,
    output logic        evt_ack
);
    logic              host_wr, host_rd_data;
    logic              ibf, obf, in_is_cmd, consume, load_out, proc, mem_we;
    logic [BYTE_W-1:0] in_byte, out_byte, status, load_val;
    logic [BYTE_W-1:0] mem_addr, mem_wdata, mem_rdata;

    // port decode of host strobes
    assign host_wr      = hst_wr && (hst_sel_cmd || hst_sel_data);
    assign host_rd_data = hst_rd && hst_sel_data && !hst_sel_cmd;
    assign hst_rdata    = hst_sel_cmd ? status : out_byte;

    hcp_flags u_flags (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_wr_cmd(hst_sel_cmd), .host_wdata(hst_wdata),
        .host_rd_data(host_rd_data), .consume(consume),
        .load_out(load_out), .load_val(load_val), .proc(proc),
        .sci(sci_pend), .smi(smi_pend),
        .ibf(ibf), .obf(obf), .in_is_cmd(in_is_cmd), .in_byte(in_byte),
        .out_byte(out_byte), .status(status)
    );

    hcp_seq u_seq (
        .clk(clk), .rst_n(rst_n),
        .ibf(ibf), .in_is_cmd(in_is_cmd), .in_byte(in_byte),
        .evt_valid(evt_valid), .evt_code(evt_code), .mem_rdata(mem_rdata),
        .consume(consume), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .load_out(load_out), .load_val(load_val),
        .proc(proc), .evt_ack(evt_ack)
    );

    hcp_space u_space (
        .clk(clk), .rst_n(rst_n),
        .addr(mem_addr), .we(mem_we), .wdata(mem_wdata), .rdata(mem_rdata)
    );

    assert_wr_sets_ibf_R2: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr |=> status[ST_IBF]);
    assert_consume_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (status[ST_IBF] && !host_wr) |=> !status[ST_IBF]);
    assert_obf_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(obf) |-> !proc);
endmodule

// File: tb/hcp_ctrl_bench.sv
module hcp_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;
    localparam int NVEC       = 19;

    // vector: {req[31:28], op[27:24] (1=write,0=read), addr, value, expected}
    localparam logic [31:0] VECS [NVEC] = '{
        {4'd10, 4'd0, 8'h00, 8'h00, 8'h01},  // R10 version
        {4'd1,  4'd0, 8'h01, 8'h00, 8'h00},  // R1 test byte reset
        {4'd1,  4'd0, 8'h02, 8'h00, 8'hFF},  // R1 complement reset
        {4'd1,  4'd0, 8'h03, 8'h00, 8'h64},  // R1 backlight reset
        {4'd11, 4'd1, 8'h01, 8'h35, 8'h00},  // R11 write test byte
        {4'd11, 4'd0, 8'h01, 8'h00, 8'h35},
        {4'd11, 4'd0, 8'h02, 8'h00, 8'hCA},
        {4'd11, 4'd1, 8'h02, 8'h11, 8'h00},  // R11 direct write ignored
        {4'd11, 4'd0, 8'h02, 8'h00, 8'hCA},
        {4'd10, 4'd1, 8'h00, 8'h07, 8'h00},  // R10 write ignored
        {4'd10, 4'd0, 8'h00, 8'h00, 8'h01},
        {4'd12, 4'd1, 8'h03, 8'h2A, 8'h00},  // R12 backlight
        {4'd12, 4'd0, 8'h03, 8'h00, 8'h2A},
        {4'd12, 4'd1, 8'h03, 8'hC8, 8'h00},  // R12 clamp
        {4'd12, 4'd0, 8'h03, 8'h00, 8'h64},
        {4'd12, 4'd1, 8'h03, 8'h64, 8'h00},  // R12 boundary
        {4'd12, 4'd0, 8'h03, 8'h00, 8'h64},
        {4'd12, 4'd1, 8'h09, 8'h55, 8'h00},  // R12 unmapped
        {4'd12, 4'd0, 8'h09, 8'h00, 8'h00}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hst_sel_cmd = 1'b0, hst_sel_data = 1'b0, hst_wr = 1'b0, hst_rd = 1'b0;
    logic [7:0] hst_wdata = '0;
    logic [7:0] hst_rdata;
    logic       sci_pend = 1'b0, smi_pend = 1'b0, evt_valid = 1'b0;
    logic [7:0] evt_code = '0;
    logic       evt_ack;
    int         n_chk = 0, n_fail = 0, n_ack = 0, cyc = 0;
    logic [7:0] got;

    hcp_ctrl u_hcp_ctrl (
        .clk(clk), .rst_n(rst_n),
        .hst_sel_cmd(hst_sel_cmd), .hst_sel_data(hst_sel_data),
        .hst_wr(hst_wr), .hst_rd(hst_rd), .hst_wdata(hst_wdata),
        .hst_rdata(hst_rdata), .sci_pend(sci_pend), .smi_pend(smi_pend),
        .evt_valid(evt_valid), .evt_code(evt_code), .evt_ack(evt_ack)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (evt_ack) n_ack <= n_ack + 1;
        if (cyc > WATCHDOG) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog act=%0d exp<%0d", cyc, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // peek at status without a strobe (called at a falling edge)
    task automatic peek_status(output logic [7:0] s);
        hst_sel_cmd = 1'b1;
        #1 s = hst_rdata;
        hst_sel_cmd = 1'b0;
    endtask

    task automatic wr_port(input logic is_cmd, input logic [7:0] b);
        @(negedge clk);
        hst_sel_cmd = is_cmd; hst_sel_data = !is_cmd; hst_wr = 1'b1; hst_wdata = b;
        @(negedge clk);
        hst_sel_cmd = 1'b0; hst_sel_data = 1'b0; hst_wr = 1'b0;
    endtask

    task automatic rd_data(output logic [7:0] d);
        @(negedge clk);
        hst_sel_data = 1'b1; hst_rd = 1'b1;
        #1 d = hst_rdata;
        @(negedge clk);
        hst_sel_data = 1'b0; hst_rd = 1'b0;
    endtask

    task automatic mem_rd(input logic [7:0] a, output logic [7:0] d);
        wr_port(1'b1, 8'h80);
        wr_port(1'b0, a);
        @(negedge clk);
        rd_data(d);
    endtask

    task automatic mem_wr(input logic [7:0] a, input logic [7:0] v);
        wr_port(1'b1, 8'h81);
        wr_port(1'b0, a);
        wr_port(1'b0, v);
        @(negedge clk);
    endtask

    initial begin
        logic [7:0] s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        peek_status(s); chk("R1 status", s, 8'h00);
        hst_sel_data = 1'b1; #1 chk("R1 data reg", hst_rdata, 8'h00); hst_sel_data = 1'b0;

        // R4 pending inputs and fixed-zero bits
        sci_pend = 1'b1; peek_status(s); chk("R4 sci", s, 8'h20);
        smi_pend = 1'b1; peek_status(s); chk("R4 sci+smi, bits4/7 zero", s, 8'h60);
        sci_pend = 1'b0; peek_status(s); chk("R4 smi", s, 8'h40);
        smi_pend = 1'b0;

        // vector table of space transactions (R6, R7, R10-R12)
        for (int i = 0; i < NVEC; i++) begin
            if (VECS[i][27:24] == 4'd1) begin
                mem_wr(VECS[i][23:16], VECS[i][15:8]);
            end else begin
                mem_rd(VECS[i][23:16], got);
                n_chk++;
                if (got !== VECS[i][7:0]) begin
                    n_fail++;
                    $display("FAIL R%0d vec %0d addr %h act=%h exp=%h",
                             VECS[i][31:28], i, VECS[i][23:16], got, VECS[i][7:0]);
                end
            end
        end

        // R2 R5 R6 status handshake through one read
        wr_port(1'b1, 8'h80);
        peek_status(s); chk("R2 cmd byte landed", s, 8'h0A);
        @(negedge clk);
        peek_status(s); chk("R5 processing after 0x80", s, 8'h0C);
        wr_port(1'b0, 8'h01);
        peek_status(s); chk("R2 data byte landed, R5 busy", s, 8'h06);
        @(negedge clk);
        peek_status(s); chk("R6 result ready", s, 8'h01);
        rd_data(got); chk("R6 read data", got, 8'h35);
        peek_status(s); chk("R3 read clears bit0", s, 8'h00);

        // R5 processing across a write, cleared after value
        wr_port(1'b1, 8'h81); @(negedge clk);
        wr_port(1'b0, 8'h03); @(negedge clk);
        peek_status(s); chk("R5 mid write", s, 8'h04);
        wr_port(1'b0, 8'h10); @(negedge clk);
        peek_status(s); chk("R7 write done no data", s, 8'h00);
        mem_rd(8'h03, got); chk("R7 stored", got, 8'h10);

        // R8 query with and without an event
        evt_valid = 1'b1; evt_code = 8'h0B;
        wr_port(1'b1, 8'h84); @(negedge clk);
        evt_valid = 1'b0;
        peek_status(s); chk("R8 query ready, no processing", s, 8'h09);
        chk("R8 ack count", 8'(n_ack), 8'd1);
        rd_data(got); chk("R8 event code", got, 8'h0B);
        evt_code = 8'h0E;
        wr_port(1'b1, 8'h84); @(negedge clk);
        rd_data(got); chk("R8 empty query", got, 8'h00);
        chk("R8 no extra ack", 8'(n_ack), 8'd1);

        // R9 other commands ignored
        wr_port(1'b1, 8'h82); @(negedge clk);
        peek_status(s); chk("R9 0x82 ignored", s, 8'h08);
        wr_port(1'b1, 8'h87); @(negedge clk);
        peek_status(s); chk("R9 0x87 ignored", s, 8'h08);
        mem_rd(8'h01, got); chk("R9 space unchanged", got, 8'h35);

        // R13 abandoned write, then stray data byte
        wr_port(1'b1, 8'h81); @(negedge clk);
        wr_port(1'b0, 8'h01); @(negedge clk);
        mem_rd(8'h01, got); chk("R13 aborted write", got, 8'h35);
        wr_port(1'b0, 8'h77); @(negedge clk);
        peek_status(s); chk("R13 stray data ignored", s, 8'h00);
        mem_rd(8'h01, got); chk("R13 space unchanged", got, 8'h35);
        mem_rd(8'h02, got); chk("R13 complement unchanged", got, 8'hCA);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule